// File: doc/BRIEF.md
# Byte Flash Programming Controller

This block is the parallel programming front end of an on-chip code flash. The pin levels of four mode inputs choose the operation: program a code byte, verify a code byte, set one of three lock bits, erase the whole array, or read the fixed identification bytes. Every operation needs the programming-enable input high and the store-enable input low. Operations that program anything also need the high-voltage-enable input high.

A byte write starts on the falling edge of the active-low program pulse and then runs on its own for a fixed number of clock cycles. While the write is in progress, a verify read of the address being written returns the inverse of bit 7 of the new data; this lets software poll for completion. A chip erase happens only if the program pulse stays low for a full hold window. It returns every byte to FFH and clears all lock bits. The ready output is low while the block is busy. Lock bits limit what the interface may do: bit 0 stops code programming, bit 1 stops verify reads, and bit 2 raises an output that forbids execution from external memory.

The flash array is a behavioural register array. It is initialised to the erased state on reset.

Top module: `byte_flash_prog_ctrl`

## Requirements
- R1: After a synchronous reset, ready is 1, lock_bits is 000, busy_err is 0, ext_exec_off is 0, every array byte reads FFH, and rdata is FFH.
- R2: mode_pins selects the operation: 0111 programs a code byte, 0011 verifies a code byte, 1111, 1100 and 1010 set lock bit 0, 1 and 2, 1000 erases the chip, and 0000 reads identification bytes. Every other value does nothing and reads FFH.
- R3: A falling edge of prog_pulse_n in code-program mode, with pgm_active=1, store_n=0 and vpp_hi=1, drives ready low from the next cycle for exactly WRITE_CYCLES cycles. The pending byte is stored when ready rises again. Lock-bit writes use the same timing.
- R4: Programming can only clear bits: the stored byte becomes the old byte AND the written data. An erased byte reads FFH.
- R5: While a code write is pending, a verify read of its address returns the inverse of bit 7 of the written data in bit 7, and the old stored bits in bits 6:0.
- R6: A chip erase takes effect only when prog_pulse_n is sampled low on ERASE_HOLD consecutive clock edges; ready is low during that window. The erase sets every byte to FFH and clears all lock bits. A shorter low pulse changes nothing.
- R7: In identification mode, address 30H reads 1EH, 31H reads 51H, and 32H reads FFH (or 05H when LOW_VPP=1). Any other address reads FFH.
- R8: With lock bit 0 set, a code-program request is ignored: ready stays 1 and the array is unchanged.
- R9: With lock bit 1 set, verify reads return FFH.
- R10: ext_exec_off follows lock bit 2.
- R11: A program, lock or erase request made while a write is pending is ignored, and busy_err is set and held until reset.
- R12: Reads need pgm_active=1 and store_n=0, otherwise rdata is FFH. Programming also needs vpp_hi=1, otherwise the request is ignored.
- R13: rdata is registered: it reflects the inputs and stored state sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_active | input | 1 | Programming interface enable |
| store_n | input | 1 | Active-low store enable |
| prog_pulse_n | input | 1 | Active-low program pulse |
| vpp_hi | input | 1 | High programming voltage present |
| mode_pins | input | 4 | Operation select levels |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Data to program |
| rdata | output | 8 | Read data (registered) |
| ready | output | 1 | 1 = idle, 0 = busy |
| lock_bits | output | 3 | Lock bit state |
| ext_exec_off | output | 1 | External execution inhibited |
| busy_err | output | 1 | Sticky busy-collision flag |

## Verification
The hardest case to reach is a request that collides with a write in progress. The stimulus starts a write, raises the pulse, and lowers it again a few cycles later while ready is still low. The bench then checks three things: busy_err is set, the first byte is stored, and the address of the second request is still erased. Data polling is reached by switching to verify mode on the same address right after the pulse. The lock-bit limits are checked by setting the bits one at a time and repeating the same requests after each step. The erase window is tested twice: once with a pulse that is released halfway, and once with a pulse held for the full window.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WR_CODE,
        OP_RD_CODE,
        OP_WR_LB1,
        OP_WR_LB2,
        OP_WR_LB3,
        OP_ERASE,
        OP_RD_SIG
    } op_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WRITE,
        SQ_ERASE
    } sq_t;

    typedef enum logic [1:0] {
        WK_CODE,
        WK_LB1,
        WK_LB2,
        WK_LB3
    } wkind_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam logic [7:0] SIG_MAKER   = 8'h1E;
    localparam logic [7:0] SIG_FAMILY  = 8'h51;
    localparam logic [7:0] SIG_HIGH_V  = 8'hFF;
    localparam logic [7:0] SIG_LOW_V   = 8'h05;

    // Pin-level operation table
    function automatic op_t decode_mode(input logic [3:0] m);
        case (m)
            4'b0111: return OP_WR_CODE;
            4'b0011: return OP_RD_CODE;
            4'b1111: return OP_WR_LB1;
            4'b1100: return OP_WR_LB2;
            4'b1010: return OP_WR_LB3;
            4'b1000: return OP_ERASE;
            4'b0000: return OP_RD_SIG;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic is_program_op(input op_t op);
        return (op == OP_WR_CODE) || (op == OP_WR_LB1) || (op == OP_WR_LB2) ||
               (op == OP_WR_LB3) || (op == OP_ERASE);
    endfunction

    function automatic logic [7:0] sig_byte(input logic [15:0] a, input logic low_vpp);
        case (a)
            16'h0030: return SIG_MAKER;
            16'h0031: return SIG_FAMILY;
            16'h0032: return low_vpp ? SIG_LOW_V : SIG_HIGH_V;
            default:  return ERASED_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/fpc_mode_decode.sv
module fpc_mode_decode
    import fpc_pkg::*;
(
    input  logic       pgm_active,
    input  logic       store_n,
    input  logic       vpp_hi,
    input  logic [3:0] mode_pins,
    output op_t        op,
    output logic       rd_ok,
    output logic       wr_ok
);
    always_comb begin
        op    = decode_mode(mode_pins);
        rd_ok = pgm_active && !store_n;
        wr_ok = pgm_active && !store_n && vpp_hi;
    end
endmodule

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
    import fpc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 1500,
    parameter int ERASE_HOLD   = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_pulse_n,
    input  op_t               op,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              prog_locked,
    output logic              busy,
    output logic              writing_code,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [7:0]        pend_data,
    output logic              commit_code,
    output logic [2:0]        commit_lock,
    output logic              erase_go,
    output logic              err_flag
);
    localparam int MAX_CNT = (WRITE_CYCLES > ERASE_HOLD) ? WRITE_CYCLES : ERASE_HOLD;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_HOLD - 1);

    sq_t              state;
    wkind_t           kind;
    logic [CNT_W-1:0] cnt;
    logic             pulse_q;
    logic             fall;
    logic             write_done;

    always_comb begin
        fall         = pulse_q && !prog_pulse_n;
        write_done   = (state == SQ_WRITE) && (cnt == WR_LAST);
        erase_go     = (state == SQ_ERASE) && !prog_pulse_n && (cnt == ER_LAST);
        busy         = (state != SQ_IDLE);
        writing_code = (state == SQ_WRITE) && (kind == WK_CODE);
        commit_code  = write_done && (kind == WK_CODE);
    end

    for (genvar k = 0; k < 3; k++) begin : g_lock_commit
        assign commit_lock[k] = write_done && (kind == wkind_t'(2'(k + 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            kind      <= WK_CODE;
            cnt       <= '0;
            pulse_q   <= 1'b1;
            pend_addr <= '0;
            pend_data <= '0;
            err_flag  <= 1'b0;
        end else begin
            pulse_q <= prog_pulse_n;
            case (state)
                SQ_IDLE: begin
                    if (fall && wr_ok) begin
                        case (op)
                            OP_WR_CODE: begin
                                if (!prog_locked) begin
                                    state     <= SQ_WRITE;
                                    kind      <= WK_CODE;
                                    cnt       <= '0;
                                    pend_addr <= addr;
                                    pend_data <= wdata;
                                end
                            end
                            OP_WR_LB1: begin
                                state <= SQ_WRITE;
                                kind  <= WK_LB1;
                                cnt   <= '0;
                            end
                            OP_WR_LB2: begin
                                state <= SQ_WRITE;
                                kind  <= WK_LB2;
                                cnt   <= '0;
                            end
                            OP_WR_LB3: begin
                                state <= SQ_WRITE;
                                kind  <= WK_LB3;
                                cnt   <= '0;
                            end
                            OP_ERASE: begin
                                state <= SQ_ERASE;
                                cnt   <= CNT_W'(1);
                            end
                            default: ;
                        endcase
                    end
                end
                SQ_WRITE: begin
                    if (fall && wr_ok && is_program_op(op)) begin
                        err_flag <= 1'b1;
                    end
                    if (write_done) begin
                        state <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_ERASE: begin
                    if (prog_pulse_n || erase_go) begin
                        state <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpc_store.sv
module fpc_store
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_code,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [7:0]        pend_data,
    input  logic [2:0]        commit_lock,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    output logic [2:0]        lock_bits
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase_go) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ERASED_BYTE;
            end
        end else if (commit_code) begin
            mem[pend_addr] <= mem[pend_addr] & pend_data;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_lock
        always_ff @(posedge clk) begin
            if (rst || erase_go) begin
                lock_bits[k] <= 1'b0;
            end else if (commit_lock[k]) begin
                lock_bits[k] <= 1'b1;
            end
        end
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/fpc_read_path.sv
module fpc_read_path
    import fpc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit LOW_VPP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        rd_byte,
    input  logic              verify_locked,
    input  logic              writing_code,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic [7:0]        pend_data,
    output logic [7:0]        rdata
);
    logic [7:0] rd_next;

    always_comb begin
        rd_next = ERASED_BYTE;
        if (rd_ok) begin
            case (op)
                OP_RD_CODE: begin
                    if (verify_locked) begin
                        rd_next = ERASED_BYTE;
                    end else if (writing_code && (addr == pend_addr)) begin
                        rd_next = {~pend_data[7], rd_byte[6:0]};
                    end else begin
                        rd_next = rd_byte;
                    end
                end
                OP_RD_SIG: rd_next = sig_byte(16'(addr), LOW_VPP);
                default:   rd_next = ERASED_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= ERASED_BYTE;
        end else begin
            rdata <= rd_next;
        end
    end
endmodule

// File: rtl/byte_flash_prog_ctrl.sv
module byte_flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 1500,
    parameter int ERASE_HOLD   = 10000,
    parameter bit LOW_VPP      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_active,
    input  logic              store_n,
    input  logic              prog_pulse_n,
    input  logic              vpp_hi,
    input  logic [3:0]        mode_pins,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready,
    output logic [2:0]        lock_bits,
    output logic              ext_exec_off,
    output logic              busy_err
);
    op_t               op;
    logic              rd_ok;
    logic              wr_ok;
    logic              busy;
    logic              writing_code;
    logic [ADDR_W-1:0] pend_addr;
    logic [7:0]        pend_data;
    logic              commit_code;
    logic [2:0]        commit_lock;
    logic              erase_go;
    logic [7:0]        rd_byte;

    fpc_mode_decode u_decode (
        .pgm_active (pgm_active),
        .store_n    (store_n),
        .vpp_hi     (vpp_hi),
        .mode_pins  (mode_pins),
        .op         (op),
        .rd_ok      (rd_ok),
        .wr_ok      (wr_ok)
    );

    fpc_sequencer #(
        .ADDR_W       (ADDR_W),
        .WRITE_CYCLES (WRITE_CYCLES),
        .ERASE_HOLD   (ERASE_HOLD)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .prog_pulse_n (prog_pulse_n),
        .op           (op),
        .wr_ok        (wr_ok),
        .addr         (addr),
        .wdata        (wdata),
        .prog_locked  (lock_bits[0]),
        .busy         (busy),
        .writing_code (writing_code),
        .pend_addr    (pend_addr),
        .pend_data    (pend_data),
        .commit_code  (commit_code),
        .commit_lock  (commit_lock),
        .erase_go     (erase_go),
        .err_flag     (busy_err)
    );

    fpc_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit_code (commit_code),
        .pend_addr   (pend_addr),
        .pend_data   (pend_data),
        .commit_lock (commit_lock),
        .erase_go    (erase_go),
        .rd_addr     (addr),
        .rd_byte     (rd_byte),
        .lock_bits   (lock_bits)
    );

    fpc_read_path #(
        .ADDR_W  (ADDR_W),
        .LOW_VPP (LOW_VPP)
    ) u_read (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .rd_ok         (rd_ok),
        .addr          (addr),
        .rd_byte       (rd_byte),
        .verify_locked (lock_bits[1]),
        .writing_code  (writing_code),
        .pend_addr     (pend_addr),
        .pend_data     (pend_data),
        .rdata         (rdata)
    );

    assign ready        = !busy;
    assign ext_exec_off = lock_bits[2];
endmodule

// File: rtl/byte_flash_prog_ctrl_chk.sv
module byte_flash_prog_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pgm_active,
    input logic              store_n,
    input logic              prog_pulse_n,
    input logic [3:0]        mode_pins,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata,
    input logic              ready,
    input logic [2:0]        lock_bits,
    input logic              busy_err
);
    // R3: busy only begins after a high-to-low program pulse edge
    assert_ready_fall_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ready) && !$past(rst) && !$past(rst, 2)) |->
        (!$past(prog_pulse_n) && $past(prog_pulse_n, 2)));

    // R11: collision flag is sticky
    assert_sticky_err_R11: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> busy_err);

    // R6: lock bits clear only at the end of a held-low erase pulse
    assert_lock_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(lock_bits) != 3'b000) && (lock_bits == 3'b000)) |->
        !$past(prog_pulse_n));

    // R9: verify lock forces erased-looking reads
    assert_verify_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(lock_bits[1]) && ($past(mode_pins) == 4'b0011) &&
         $past(pgm_active) && !$past(store_n)) |-> (rdata == 8'hFF));

    // R7: maker identification byte
    assert_sig_maker_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(mode_pins) == 4'b0000) && $past(pgm_active) &&
         !$past(store_n) && ($past(addr) == ADDR_W'('h30))) |-> (rdata == 8'h1E));

    // R8: program lock keeps the block idle on a code-program request
    assert_prog_lock_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ready && lock_bits[0] && $past(prog_pulse_n) &&
         !prog_pulse_n && (mode_pins == 4'b0111)) |=> ready);
endmodule

bind byte_flash_prog_ctrl byte_flash_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pgm_active   (pgm_active),
    .store_n      (store_n),
    .prog_pulse_n (prog_pulse_n),
    .mode_pins    (mode_pins),
    .addr         (addr),
    .rdata        (rdata),
    .ready        (ready),
    .lock_bits    (lock_bits),
    .busy_err     (busy_err)
);

// File: tb/byte_flash_prog_ctrl_tb_top.sv
module byte_flash_prog_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int WC = 20;
    localparam int EH = 40;

    localparam logic [3:0] MD_WR  = 4'b0111;
    localparam logic [3:0] MD_RD  = 4'b0011;
    localparam logic [3:0] MD_LB1 = 4'b1111;
    localparam logic [3:0] MD_LB2 = 4'b1100;
    localparam logic [3:0] MD_LB3 = 4'b1010;
    localparam logic [3:0] MD_ER  = 4'b1000;
    localparam logic [3:0] MD_SIG = 4'b0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pgm_active = 1'b1;
    logic          store_n = 1'b0;
    logic          prog_pulse_n = 1'b1;
    logic          vpp_hi = 1'b1;
    logic [3:0]    mode_pins = MD_RD;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          ready;
    logic [2:0]    lock_bits;
    logic          ext_exec_off;
    logic          busy_err;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    started = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    byte_flash_prog_ctrl #(
        .ADDR_W       (AW),
        .WRITE_CYCLES (WC),
        .ERASE_HOLD   (EH),
        .LOW_VPP      (1'b0)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pgm_active   (pgm_active),
        .store_n      (store_n),
        .prog_pulse_n (prog_pulse_n),
        .vpp_hi       (vpp_hi),
        .mode_pins    (mode_pins),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .ready        (ready),
        .lock_bits    (lock_bits),
        .ext_exec_off (ext_exec_off),
        .busy_err     (busy_err)
    );

    // Behavioural reference model
    logic [7:0] m_mem [0:(1<<AW)-1];
    int         m_state = 0;
    int         m_cnt = 0;
    int         m_kind = 0;
    logic [2:0] m_lb = 3'b000;
    logic       m_err = 1'b0;
    logic       m_prev = 1'b1;
    logic [AW-1:0] m_paddr = '0;
    logic [7:0] m_pdata = '0;
    logic [7:0] e_rdata = 8'hFF;

    always @(posedge clk) begin
        bit rd_ok;
        bit wr_ok;
        bit fall;
        started = 1'b1;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_state = 0; m_cnt = 0; m_kind = 0; m_lb = 3'b000; m_err = 1'b0;
            m_prev = 1'b1; e_rdata = 8'hFF;
        end else begin
            rd_ok = pgm_active && !store_n;
            wr_ok = rd_ok && vpp_hi;
            if (!rd_ok) e_rdata = 8'hFF;
            else if (mode_pins == MD_RD) begin
                if (m_lb[1]) e_rdata = 8'hFF;
                else if (m_state == 1 && m_kind == 0 && addr == m_paddr)
                    e_rdata = {~m_pdata[7], m_mem[addr][6:0]};
                else e_rdata = m_mem[addr];
            end else if (mode_pins == MD_SIG) begin
                if (addr == 8'h30) e_rdata = 8'h1E;
                else if (addr == 8'h31) e_rdata = 8'h51;
                else e_rdata = 8'hFF;
            end else e_rdata = 8'hFF;
            fall = m_prev && !prog_pulse_n;
            if (m_state == 0) begin
                if (fall && wr_ok) begin
                    if (mode_pins == MD_WR && !m_lb[0]) begin
                        m_state = 1; m_cnt = 0; m_kind = 0; m_paddr = addr; m_pdata = wdata;
                    end else if (mode_pins == MD_LB1) begin m_state = 1; m_cnt = 0; m_kind = 1; end
                    else if (mode_pins == MD_LB2) begin m_state = 1; m_cnt = 0; m_kind = 2; end
                    else if (mode_pins == MD_LB3) begin m_state = 1; m_cnt = 0; m_kind = 3; end
                    else if (mode_pins == MD_ER) begin m_state = 2; m_cnt = 1; end
                end
            end else if (m_state == 1) begin
                if (fall && wr_ok && (mode_pins inside {MD_WR, MD_LB1, MD_LB2, MD_LB3, MD_ER}))
                    m_err = 1'b1;
                if (m_cnt == WC - 1) begin
                    if (m_kind == 0) m_mem[m_paddr] = m_mem[m_paddr] & m_pdata;
                    else m_lb[m_kind-1] = 1'b1;
                    m_state = 0;
                end else m_cnt++;
            end else begin
                if (prog_pulse_n) m_state = 0;
                else if (m_cnt == EH - 1) begin
                    foreach (m_mem[i]) m_mem[i] = 8'hFF;
                    m_lb = 3'b000;
                    m_state = 0;
                end else m_cnt++;
            end
            m_prev = prog_pulse_n;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (rdata !== e_rdata || ready !== (m_state == 0) || lock_bits !== m_lb ||
                ext_exec_off !== m_lb[2] || busy_err !== m_err) begin
                n_bad++;
                $display("FAIL %s: rdata=%h ready=%b lock=%b ext=%b err=%b expected rdata=%h ready=%b lock=%b ext=%b err=%b",
                         tag, rdata, ready, lock_bits, ext_exec_off, busy_err,
                         e_rdata, (m_state == 0), m_lb, m_lb[2], m_err);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic start_op(input logic [3:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        mode_pins = m; addr = a; wdata = d; prog_pulse_n = 1'b0;
        tick(2);
        prog_pulse_n = 1'b1;
    endtask

    task automatic full_op(input logic [3:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        start_op(m, a, d);
        tick(WC + 2);
        mode_pins = MD_RD;
    endtask

    task automatic rd(input logic [3:0] m, input logic [AW-1:0] a);
        mode_pins = m; addr = a;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        tag = "R1";
        chk("R1 ready", {7'd0, ready}, 8'h01);
        chk("R1 rdata", rdata, 8'hFF);
        chk("R1 lock", {5'd0, lock_bits}, 8'h00);

        tag = "R7";
        rd(MD_SIG, 8'h30); chk("R7 30H", rdata, 8'h1E);
        rd(MD_SIG, 8'h31); chk("R7 31H", rdata, 8'h51);
        rd(MD_SIG, 8'h32); chk("R7 32H", rdata, 8'hFF);
        rd(MD_SIG, 8'h33); chk("R7 33H", rdata, 8'hFF);

        tag = "R3";
        mode_pins = MD_WR; addr = 8'h05; wdata = 8'hA5; prog_pulse_n = 1'b0;
        tick(1);
        chk("R3 busy", {7'd0, ready}, 8'h00);
        tick(1); prog_pulse_n = 1'b1;
        tag = "R5";
        rd(MD_RD, 8'h05);
        chk("R5 poll", rdata, 8'h7F);
        tick(WC);
        tag = "R13";
        chk("R3 done", {7'd0, ready}, 8'h01);
        rd(MD_RD, 8'h05); chk("R4 stored", rdata, 8'hA5);

        tag = "R4";
        full_op(MD_WR, 8'h05, 8'h0F);
        rd(MD_RD, 8'h05); chk("R4 and", rdata, 8'h05);

        tag = "R11";
        start_op(MD_WR, 8'h06, 8'h3C);
        tick(2);
        start_op(MD_WR, 8'h07, 8'h00);
        tick(WC);
        chk("R11 err", {7'd0, busy_err}, 8'h01);
        rd(MD_RD, 8'h06); chk("R11 first", rdata, 8'h3C);
        rd(MD_RD, 8'h07); chk("R11 second ignored", rdata, 8'hFF);

        tag = "R12";
        vpp_hi = 1'b0;
        full_op(MD_WR, 8'h08, 8'h00);
        vpp_hi = 1'b1;
        rd(MD_RD, 8'h08); chk("R12 no vpp", rdata, 8'hFF);
        store_n = 1'b1;
        rd(MD_RD, 8'h05); chk("R12 store off", rdata, 8'hFF);
        store_n = 1'b0;

        tag = "R2";
        start_op(4'b0101, 8'h05, 8'h00);
        chk("R2 unused mode", {7'd0, ready}, 8'h01);
        rd(4'b0101, 8'h05); chk("R2 unused read", rdata, 8'hFF);

        tag = "R6";
        mode_pins = MD_ER; prog_pulse_n = 1'b0;
        tick(EH / 2);
        prog_pulse_n = 1'b1;
        tick(2);
        rd(MD_RD, 8'h05); chk("R6 short erase", rdata, 8'h05);

        tag = "R8";
        full_op(MD_LB1, 8'h00, 8'h00);
        chk("R8 lock1", {5'd0, lock_bits}, 8'h01);
        start_op(MD_WR, 8'h09, 8'h00);
        chk("R8 idle", {7'd0, ready}, 8'h01);
        rd(MD_RD, 8'h09); chk("R8 unchanged", rdata, 8'hFF);

        tag = "R9";
        full_op(MD_LB2, 8'h00, 8'h00);
        rd(MD_RD, 8'h05); chk("R9 verify off", rdata, 8'hFF);

        tag = "R10";
        full_op(MD_LB3, 8'h00, 8'h00);
        chk("R10 ext", {7'd0, ext_exec_off}, 8'h01);

        tag = "R6";
        mode_pins = MD_ER; prog_pulse_n = 1'b0;
        tick(3);
        chk("R6 busy", {7'd0, ready}, 8'h00);
        tick(EH);
        prog_pulse_n = 1'b1;
        tick(2);
        chk("R6 lock cleared", {5'd0, lock_bits}, 8'h00);
        rd(MD_RD, 8'h05); chk("R6 erased", rdata, 8'hFF);

        tag = "R4";
        full_op(MD_WR, 8'h05, 8'h5A);
        rd(MD_RD, 8'h05); chk("R4 after erase", rdata, 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL %s: watchdog expired, actual=running expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule